// File: doc/BRIEF.md
# In-Order Issue Interlock Stall Unit

This block sits at the issue point of a single-issue, five-stage, in-order pipeline and decides every cycle whether the instruction presented to it may leave. Each instruction is described by a valid flag, an operation class, an optional destination register and up to two optional source registers. Every register reference carries a flag that selects the integer file or the FP file. The unit keeps a short shift history of the last few issue slots. For each slot it knows whether an instruction issued or a bubble went out, what class the instruction was and what it wrote. A consumer whose source matches a recent producer is held until the spacing that the producer/consumer class pair requires has passed.

The required spacing is set per class pair by parameters. Any mix of independent instructions, bubbles and idle cycles between the two instructions counts toward that spacing. The instruction that directly follows an issued branch fills the delay slot and is never held. While the unit holds an instruction, the instruction stays at issue and a no-op is sent down the pipe. Fetch, forwarding, execution and branch resolution stay outside this block.

Top module: `ilk_stall_unit`

## Requirements
- R1: A load (class code 1) followed directly by any instruction that reads the loaded register through either source is held for exactly one cycle.
- R2: An FP ALU result (class code 3) read by a later FP ALU instruction needs three cycles of spacing, so a directly following dependent FP ALU instruction is held for three cycles.
- R3: An FP ALU result used as the data operand of a store (class code 2, data on source B) needs two cycles of spacing.
- R4: An integer ALU result (class code 4) read by a branch (class code 5) needs one cycle of spacing. An integer ALU result used on source A as a load address needs none.
- R5: When a branch issued in the previous cycle, the current instruction is its delay slot and is never held, whatever it depends on.
- R6: With a required spacing of N and k issue slots (instructions, bubbles or idle cycles) between producer and consumer, the consumer is held for max(0, N−k) cycles.
- R7: Only read-after-write matches hold an instruction. Writing a register that an earlier instruction read never causes a hold.
- R8: A match needs the same register file flag and the same index. Integer register 0 never creates a dependence, either as a destination or as a source.
- R9: hold and bubble are asserted together, issue equals valid and not hold, and an invalid input never holds.
- R10: Reset clears the whole issue history, so no hold arises from an instruction issued before reset.
- R11: Every producer/consumer class pair not named in R1 to R4 (class code 0 is the generic class) needs zero spacing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An instruction is presented for issue |
| in_cls | input | 3 | Operation class: 0 generic, 1 load, 2 store, 3 FP ALU, 4 integer ALU, 5 branch |
| in_dst_en | input | 1 | Instruction writes a destination register |
| in_dst_fp | input | 1 | Destination is in the FP file |
| in_dst_idx | input | IDX_W | Destination register index |
| in_sa_en | input | 1 | Source A is read (a load or store address) |
| in_sa_fp | input | 1 | Source A is in the FP file |
| in_sa_idx | input | IDX_W | Source A register index |
| in_sb_en | input | 1 | Source B is read (a store's data) |
| in_sb_fp | input | 1 | Source B is in the FP file |
| in_sb_idx | input | IDX_W | Source B register index |
| hold | output | 1 | Keep the presented instruction at issue |
| bubble | output | 1 | Send a no-op into the next stage this cycle |
| issue | output | 1 | The presented instruction leaves this cycle |

## Verification
The bench runs a cycle-by-cycle stream that includes each stalling class pair with its consumer placed right after the producer. If the latencies were off by one, the bubble runs would come out one cycle short or long. It places independent instructions and idle cycles inside the spacing window, which catches a history that only ages on issue. It puts an FP consumer in a branch delay slot, where a missing exemption shows up as a spurious hold, and follows it with a second consumer that must still be held. Other cases cover anti-dependences, file mismatches, integer register 0 and the zero-spacing pairs, where a loose comparator would add stalls, and a reset in the middle of a pending hazard, which exposes history that survives reset.

// File: rtl/ilk_pkg.sv
`timescale 1ns/1ps
package ilk_pkg;

   // Operation classes presented at issue (encoding is part of the port contract)
   typedef enum logic [2:0] {
      CLS_OTHER  = 3'd0,
      CLS_LOAD   = 3'd1,
      CLS_STORE  = 3'd2,
      CLS_FPALU  = 3'd3,
      CLS_INTALU = 3'd4,
      CLS_BRANCH = 3'd5
   } op_cls_e;

   // Spacing (in issue slots) a consumer must trail a producer by.
   // data_role marks source B of a store (the stored value).
   function automatic int ilk_need(op_cls_e prod, op_cls_e cons, logic data_role,
                                   int l_ld, int l_ff, int l_fs, int l_ib);
      int n;
      n = 0;
      case (prod)
         CLS_LOAD:   n = l_ld;
         CLS_FPALU: begin
            if (cons == CLS_FPALU)                   n = l_ff;
            else if (cons == CLS_STORE && data_role) n = l_fs;
         end
         CLS_INTALU: if (cons == CLS_BRANCH)         n = l_ib;
         default:    n = 0;
      endcase
      return n;
   endfunction

   function automatic int ilk_max4(int a, int b, int c, int d);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      if (m < 1) m = 1;
      return m;
   endfunction

endpackage

// File: rtl/ilk_history.sv
`timescale 1ns/1ps
// Shift history of issue slots: entry i describes the slot i+1 cycles ago.
module ilk_history
   import ilk_pkg::*;
#(
   parameter int DEPTH = 3,
   parameter int IDX_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_vld,
   input  op_cls_e          push_cls,
   input  logic             push_wr,
   input  logic             push_fp,
   input  logic [IDX_W-1:0] push_idx,
   output logic             h_vld [DEPTH],
   output op_cls_e          h_cls [DEPTH],
   output logic             h_wr  [DEPTH],
   output logic             h_fp  [DEPTH],
   output logic [IDX_W-1:0] h_idx [DEPTH]
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            h_vld[i] <= 1'b0;
            h_cls[i] <= CLS_OTHER;
            h_wr[i]  <= 1'b0;
            h_fp[i]  <= 1'b0;
            h_idx[i] <= '0;
         end
      end else begin
         h_vld[0] <= push_vld;
         h_cls[0] <= push_vld ? push_cls : CLS_OTHER;
         h_wr[0]  <= push_vld & push_wr;
         h_fp[0]  <= push_fp;
         h_idx[0] <= push_idx;
         for (int i = 1; i < DEPTH; i++) begin
            h_vld[i] <= h_vld[i-1];
            h_cls[i] <= h_cls[i-1];
            h_wr[i]  <= h_wr[i-1];
            h_fp[i]  <= h_fp[i-1];
            h_idx[i] <= h_idx[i-1];
         end
      end
   end

endmodule

// File: rtl/ilk_slot_cmp.sv
`timescale 1ns/1ps
// Compares the issuing instruction against one history entry of fixed age.
module ilk_slot_cmp
   import ilk_pkg::*;
#(
   parameter int IDX_W      = 5,
   parameter int AGE        = 0,
   parameter int LAT_LD_USE = 1,
   parameter int LAT_FP_FP  = 3,
   parameter int LAT_FP_ST  = 2,
   parameter int LAT_INT_BR = 1
) (
   input  logic             h_vld,
   input  op_cls_e          h_cls,
   input  logic             h_wr,
   input  logic             h_fp,
   input  logic [IDX_W-1:0] h_idx,
   input  op_cls_e          c_cls,
   input  logic             sa_en,
   input  logic             sa_fp,
   input  logic [IDX_W-1:0] sa_idx,
   input  logic             sb_en,
   input  logic             sb_fp,
   input  logic [IDX_W-1:0] sb_idx,
   output logic             hit
);

   logic match_a, match_b;
   int   need_a, need_b;

   always_comb begin
      match_a = sa_en && (sa_fp == h_fp) && (sa_idx == h_idx) && (sa_fp || sa_idx != '0);
      match_b = sb_en && (sb_fp == h_fp) && (sb_idx == h_idx) && (sb_fp || sb_idx != '0);
      need_a  = ilk_need(h_cls, c_cls, 1'b0, LAT_LD_USE, LAT_FP_FP, LAT_FP_ST, LAT_INT_BR);
      need_b  = ilk_need(h_cls, c_cls, (c_cls == CLS_STORE),
                         LAT_LD_USE, LAT_FP_FP, LAT_FP_ST, LAT_INT_BR);
      hit     = h_vld && h_wr && ((match_a && (AGE < need_a)) || (match_b && (AGE < need_b)));
   end

endmodule

// File: rtl/ilk_stall_unit.sv
`timescale 1ns/1ps
module ilk_stall_unit
   import ilk_pkg::*;
#(
   parameter int IDX_W      = 5,
   parameter int LAT_LD_USE = 1,
   parameter int LAT_FP_FP  = 3,
   parameter int LAT_FP_ST  = 2,
   parameter int LAT_INT_BR = 1,
   parameter bit DELAY_SLOT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [2:0]       in_cls,
   input  logic             in_dst_en,
   input  logic             in_dst_fp,
   input  logic [IDX_W-1:0] in_dst_idx,
   input  logic             in_sa_en,
   input  logic             in_sa_fp,
   input  logic [IDX_W-1:0] in_sa_idx,
   input  logic             in_sb_en,
   input  logic             in_sb_fp,
   input  logic [IDX_W-1:0] in_sb_idx,
   output logic             hold,
   output logic             bubble,
   output logic             issue
);

   localparam int DEPTH = ilk_max4(LAT_LD_USE, LAT_FP_FP, LAT_FP_ST, LAT_INT_BR);

   if (IDX_W < 1) begin : g_bad_idx
      $error("ilk_stall_unit: IDX_W must be at least 1");
   end
   if (LAT_LD_USE < 0 || LAT_FP_FP < 0 || LAT_FP_ST < 0 || LAT_INT_BR < 0) begin : g_bad_lat
      $error("ilk_stall_unit: latencies must not be negative");
   end

   op_cls_e          c_cls;
   logic             push_wr;
   logic             hazard;
   logic             in_slot;
   logic             stall;
   logic [DEPTH-1:0] hit;

   logic             h_vld [DEPTH];
   op_cls_e          h_cls [DEPTH];
   logic             h_wr  [DEPTH];
   logic             h_fp  [DEPTH];
   logic [IDX_W-1:0] h_idx [DEPTH];

   assign c_cls   = op_cls_e'(in_cls);
   // integer register 0 is never a real destination
   assign push_wr = in_dst_en && (in_dst_fp || in_dst_idx != '0);

   ilk_history #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_hist (
      .clk      (clk),
      .rst_n    (rst_n),
      .push_vld (issue),
      .push_cls (c_cls),
      .push_wr  (push_wr),
      .push_fp  (in_dst_fp),
      .push_idx (in_dst_idx),
      .h_vld    (h_vld),
      .h_cls    (h_cls),
      .h_wr     (h_wr),
      .h_fp     (h_fp),
      .h_idx    (h_idx)
   );

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      ilk_slot_cmp #(
         .IDX_W      (IDX_W),
         .AGE        (g),
         .LAT_LD_USE (LAT_LD_USE),
         .LAT_FP_FP  (LAT_FP_FP),
         .LAT_FP_ST  (LAT_FP_ST),
         .LAT_INT_BR (LAT_INT_BR)
      ) u_cmp (
         .h_vld  (h_vld[g]),
         .h_cls  (h_cls[g]),
         .h_wr   (h_wr[g]),
         .h_fp   (h_fp[g]),
         .h_idx  (h_idx[g]),
         .c_cls  (c_cls),
         .sa_en  (in_sa_en),
         .sa_fp  (in_sa_fp),
         .sa_idx (in_sa_idx),
         .sb_en  (in_sb_en),
         .sb_fp  (in_sb_fp),
         .sb_idx (in_sb_idx),
         .hit    (hit[g])
      );
   end

   assign hazard = |hit;

   if (DELAY_SLOT) begin : g_dslot
      assign in_slot = h_vld[0] && (h_cls[0] == CLS_BRANCH);
   end else begin : g_nodslot
      assign in_slot = 1'b0;
   end

   assign stall  = in_valid && hazard && !in_slot;
   assign hold   = stall;
   assign bubble = stall;
   assign issue  = in_valid && !stall;

endmodule

// File: rtl/ilk_stall_chk.sv
`timescale 1ns/1ps
module ilk_stall_chk
   import ilk_pkg::*;
#(
   parameter int IDX_W      = 5,
   parameter int LAT_LD_USE = 1,
   parameter int LAT_FP_FP  = 3,
   parameter int LAT_FP_ST  = 2,
   parameter int LAT_INT_BR = 1,
   parameter bit DELAY_SLOT = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [2:0]       in_cls,
   input logic             in_dst_en,
   input logic             in_dst_fp,
   input logic [IDX_W-1:0] in_dst_idx,
   input logic             in_sa_en,
   input logic             in_sa_fp,
   input logic [IDX_W-1:0] in_sa_idx,
   input logic             in_sb_en,
   input logic             in_sb_fp,
   input logic [IDX_W-1:0] in_sb_idx,
   input logic             hold,
   input logic             bubble,
   input logic             issue
);

   localparam int DEPTH = ilk_max4(LAT_LD_USE, LAT_FP_FP, LAT_FP_ST, LAT_INT_BR);

   logic             armed;
   logic             p_issue;
   logic [2:0]       p_cls;
   logic             p_wr;
   logic             p_fp;
   logic [IDX_W-1:0] p_idx;
   int               run;
   logic             reads_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed   <= 1'b0;
         p_issue <= 1'b0;
         p_cls   <= 3'd0;
         p_wr    <= 1'b0;
         p_fp    <= 1'b0;
         p_idx   <= '0;
         run     <= 0;
      end else begin
         armed   <= 1'b1;
         p_issue <= issue;
         p_cls   <= in_cls;
         p_wr    <= in_dst_en && (in_dst_fp || in_dst_idx != '0);
         p_fp    <= in_dst_fp;
         p_idx   <= in_dst_idx;
         run     <= hold ? run + 1 : 0;
      end
   end

   assign reads_prev = (in_sa_en && in_sa_fp == p_fp && in_sa_idx == p_idx) ||
                       (in_sb_en && in_sb_fp == p_fp && in_sb_idx == p_idx);

   AST_LOAD_USE: assert property (@(posedge clk) disable iff (!rst_n)
      (LAT_LD_USE > 0 && armed && p_issue && p_cls == CLS_LOAD && p_wr && in_valid && reads_prev)
      |-> hold); // R1

   AST_HOLD_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      hold |-> (run < DEPTH)); // R2

   AST_INT_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
      (LAT_INT_BR > 0 && armed && p_issue && p_cls == CLS_INTALU && p_wr && in_valid &&
       in_cls == CLS_BRANCH && reads_prev) |-> hold); // R4

   AST_DELAY_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      (DELAY_SLOT && armed && p_issue && p_cls == CLS_BRANCH) |-> !hold); // R5

   AST_IDLE_NO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |-> (!hold && !bubble && !issue)); // R9

   AST_ISSUE_XOR_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> (issue != bubble)); // R9

   AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |-> !hold); // R10

endmodule

bind ilk_stall_unit ilk_stall_chk #(
   .IDX_W      (IDX_W),
   .LAT_LD_USE (LAT_LD_USE),
   .LAT_FP_FP  (LAT_FP_FP),
   .LAT_FP_ST  (LAT_FP_ST),
   .LAT_INT_BR (LAT_INT_BR),
   .DELAY_SLOT (DELAY_SLOT)
) u_chk (.*);

// File: tb/ilk_stall_unit_bench.sv
`timescale 1ns/1ps
module ilk_stall_unit_bench;

   localparam logic [2:0] CO = 3'd0, CL = 3'd1, CS = 3'd2, CF = 3'd3, CA = 3'd4, CB = 3'd5;
   localparam logic [6:0] NO = 7'd0;

   typedef struct packed {
      logic       vld;
      logic [2:0] cls;
      logic [6:0] dst;
      logic [6:0] sa;
      logic [6:0] sb;
      logic       exp;
      logic [3:0] req;
   } vec_t;

   function automatic logic [6:0] gi(input int n);
      return {1'b1, 1'b0, 5'(n)};
   endfunction
   function automatic logic [6:0] gf(input int n);
      return {1'b1, 1'b1, 5'(n)};
   endfunction
   function automatic vec_t mk(input logic v, input logic [2:0] c, input logic [6:0] d,
                               input logic [6:0] a, input logic [6:0] b,
                               input logic e, input int r);
      return '{vld: v, cls: c, dst: d, sa: a, sb: b, exp: e, req: 4'(r)};
   endfunction

   localparam int NV = 47;
   localparam vec_t VT [NV] = '{
      mk(1, CL, gf(1),  gi(5),  NO,     0, 1),  // R1 load producer
      mk(1, CF, gf(4),  gf(1),  gf(2),  1, 1),  // R1 load-use bubble
      mk(1, CF, gf(4),  gf(1),  gf(2),  0, 1),
      mk(1, CS, NO,     gi(5),  gf(4),  1, 3),  // R3 fp -> store data
      mk(1, CS, NO,     gi(5),  gf(4),  1, 3),
      mk(1, CS, NO,     gi(5),  gf(4),  0, 3),
      mk(1, CF, gf(6),  gf(7),  gf(2),  0, 2),  // R2 fp producer
      mk(1, CF, gf(8),  gf(6),  gf(2),  1, 2),  // R2 three bubbles
      mk(1, CF, gf(8),  gf(6),  gf(2),  1, 2),
      mk(1, CF, gf(8),  gf(6),  gf(2),  1, 2),
      mk(1, CF, gf(8),  gf(6),  gf(2),  0, 2),
      mk(1, CF, gf(10), gf(11), NO,     0, 6),  // R6 producer
      mk(1, CO, gi(7),  gi(8),  NO,     0, 6),  // R6 independent filler
      mk(1, CF, gf(12), gf(10), NO,     1, 6),  // R6 two bubbles left
      mk(1, CF, gf(12), gf(10), NO,     1, 6),
      mk(1, CF, gf(12), gf(10), NO,     0, 6),
      mk(1, CF, gf(14), gf(13), NO,     0, 5),  // R5 fp producer
      mk(1, CB, NO,     gi(9),  gi(2),  0, 5),  // R5 branch
      mk(1, CF, gf(15), gf(14), NO,     0, 5),  // R5 delay slot not held
      mk(1, CF, gf(16), gf(14), NO,     1, 2),  // R2 still held after slot
      mk(1, CF, gf(16), gf(14), NO,     0, 2),
      mk(1, CA, gi(3),  gi(4),  NO,     0, 4),  // R4 int producer
      mk(1, CB, NO,     gi(3),  gi(0),  1, 4),  // R4 int -> branch
      mk(1, CB, NO,     gi(3),  gi(0),  0, 4),
      mk(1, CO, gi(17), gi(3),  NO,     0, 5),  // R5 delay slot
      mk(1, CA, gi(9),  gi(3),  NO,     0, 11), // R11
      mk(1, CL, gi(10), gi(9),  NO,     0, 4),  // R4 int -> load address
      mk(1, CA, gi(12), gi(13), gi(13), 0, 7),  // R7 reader
      mk(1, CL, gi(13), gi(14), NO,     0, 7),  // R7 anti-dependence
      mk(1, CA, gi(15), gi(16), NO,     0, 7),
      mk(1, CF, gf(5),  gf(7),  NO,     0, 8),  // R8 fp producer F5
      mk(1, CF, gf(18), gi(5),  gi(5),  0, 8),  // R8 int 5 is not fp 5
      mk(1, CF, gf(19), gf(5),  NO,     1, 8),  // R8 same file matches
      mk(1, CF, gf(19), gf(5),  NO,     1, 8),
      mk(1, CF, gf(19), gf(5),  NO,     0, 8),
      mk(1, CL, gi(0),  gi(1),  NO,     0, 8),  // R8 load to int r0
      mk(1, CA, gi(21), gi(0),  NO,     0, 8),  // R8 r0 no dependence
      mk(1, CL, gi(20), gi(1),  NO,     0, 9),  // R9 producer
      mk(0, CA, NO,     gi(20), NO,     0, 9),  // R9 invalid never held
      mk(1, CA, gi(22), gi(20), NO,     0, 6),  // R6 idle cycle counts
      mk(1, CF, gf(9),  gf(7),  NO,     0, 11), // R11 fp producer
      mk(1, CO, gi(23), gf(9),  NO,     0, 11), // R11 fp -> generic
      mk(1, CA, gi(24), gi(1),  NO,     0, 11), // R11 int producer
      mk(1, CS, NO,     gi(24), gi(24), 0, 11), // R11 int -> store
      mk(1, CL, gf(25), gi(1),  NO,     0, 1),  // R1 load producer
      mk(1, CS, NO,     gi(1),  gf(25), 1, 1),  // R1 load -> store data
      mk(1, CS, NO,     gi(1),  gf(25), 0, 1)
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic [2:0] in_cls = 3'd0;
   logic       in_dst_en = 1'b0, in_dst_fp = 1'b0;
   logic [4:0] in_dst_idx = '0;
   logic       in_sa_en = 1'b0, in_sa_fp = 1'b0;
   logic [4:0] in_sa_idx = '0;
   logic       in_sb_en = 1'b0, in_sb_fp = 1'b0;
   logic [4:0] in_sb_idx = '0;
   logic       hold, bubble, issue;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   ilk_stall_unit u_ilk_stall_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_cls(in_cls),
      .in_dst_en(in_dst_en), .in_dst_fp(in_dst_fp), .in_dst_idx(in_dst_idx),
      .in_sa_en(in_sa_en), .in_sa_fp(in_sa_fp), .in_sa_idx(in_sa_idx),
      .in_sb_en(in_sb_en), .in_sb_fp(in_sb_fp), .in_sb_idx(in_sb_idx),
      .hold(hold), .bubble(bubble), .issue(issue)
   );

   task automatic check(input logic act, input logic exp, input int req, input string what);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL R%0d %s: actual=%0b expected=%0b", req, what, act, exp);
      end
   endtask

   task automatic drive(input vec_t v);
      in_valid   = v.vld;
      in_cls     = v.cls;
      in_dst_en  = v.dst[6]; in_dst_fp = v.dst[5]; in_dst_idx = v.dst[4:0];
      in_sa_en   = v.sa[6];  in_sa_fp  = v.sa[5];  in_sa_idx  = v.sa[4:0];
      in_sb_en   = v.sb[6];  in_sb_fp  = v.sb[5];  in_sb_idx  = v.sb[4:0];
   endtask

   task automatic check_row(input vec_t v, input int row);
      check(hold,   v.exp, int'(v.req), $sformatf("row %0d hold", row));
      check(bubble, v.exp, 9, $sformatf("row %0d bubble", row));              // R9
      check(issue,  v.vld && !v.exp, 9, $sformatf("row %0d issue", row));     // R9
   endtask

   initial begin
      // reset state: a dependent-looking consumer during reset is not held (R10)
      drive(mk(1, CF, gf(2), gf(1), NO, 0, 10));
      @(negedge clk);
      @(negedge clk);
      #2;
      check(hold, 1'b0, 10, "hold during reset");    // R10
      check(bubble, 1'b0, 10, "bubble during reset"); // R10
      drive(mk(0, CO, NO, NO, NO, 0, 10));
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      for (int r = 0; r < NV; r++) begin
         drive(VT[r]);
         #2;
         check_row(VT[r], r);
         @(negedge clk);
      end

      // R10: reset in the middle of a pending fp -> fp hazard
      drive(mk(1, CF, gf(3), gf(7), NO, 0, 10));
      #2;
      check(hold, 1'b0, 10, "producer before reset");
      @(negedge clk);
      drive(mk(1, CF, gf(26), gf(3), NO, 1, 2));
      #2;
      check(hold, 1'b1, 2, "pending hazard before reset");   // R2
      #1 rst_n = 1'b0;
      #1;
      check(hold, 1'b0, 10, "hold while reset asserted");    // R10
      #1 rst_n = 1'b1;
      #0.5;
      check(hold, 1'b0, 10, "history cleared after reset");  // R10
      check(issue, 1'b1, 10, "consumer issues after reset"); // R10
      @(negedge clk);
      drive(mk(0, CO, NO, NO, NO, 0, 9));
      #2;
      check(hold, 1'b0, 9, "idle after reset");              // R9
      @(negedge clk);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #1600000;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule